// File: doc/BRIEF.md
# Serial register-bus slave with deferred commit

This block is the protocol engine of a two-wire serial slave. It sits behind a pad front end that has already recovered the bus events (START, repeated START, STOP, SCL falling edges and sampled data bits). It gives an external master block read and block write access to an internal file of 256 byte-wide registers. It also offers a side read port so that the rest of the chip can observe the committed register values.

A transaction opens with a 7-bit device address. The slave answers to one of four addresses picked by a 2-bit setting. After a write-direction address, two bytes give the starting register. Data bytes then follow to ascending registers. These bytes are not written straight into the file. They collect in a 32-byte shadow buffer, and the whole block lands in the register file in one clock when STOP arrives. A repeated START throws the buffered block away.

For a read, the master first sets the pointer with a write-direction header. It then issues a repeated START with a read-direction address. The slave shifts out registers from the pointer onward until the master refuses a byte.

Top module: `serial_reg_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth bit) an address byte whose upper 7 bits equal 0x68 plus `addr_sel` (0x68..0x6B). The lowest bit of that byte is the direction: 0 means write and 1 means read. Any other address gets no acknowledge, and the slave drives nothing further until the next START.
- R2: After a write-direction address, the slave acknowledges the next two bytes. These form a 16-bit start register address, first byte high. Only its low 8 bits select the register.
- R3: Data bytes arrive MSB first. The bytes of a block are destined for registers base, base+1, and so on, with the register index wrapping modulo 256.
- R4: While a block is buffered, no register changes. On STOP, every buffered byte is written in the same clock edge. A block may end after any whole byte, including after a single byte.
- R5: A repeated START after buffered write bytes discards them, and the register file keeps its old contents.
- R6: The buffer holds 32 bytes. Data bytes 1 to 32 are acknowledged. Byte 33 onward are not acknowledged and are not stored, and the first 32 bytes still commit at STOP.
- R7: After a read-direction address is acknowledged, the slave sends the register at the pointer, MSB first, and then further registers in ascending order, wrapping modulo 256. Only the address bytes set the pointer; write data bytes leave it unchanged.
- R8: When the master answers a read byte with NACK (SDA high in the ninth bit), the slave releases SDA and drives nothing until the next START.
- R9: After reset, SDA is released and every register reads 0.
- R10: The SDA drive changes only on an SCL falling event, and is released on START and STOP.
- R11: `host_rdata` shows the committed content of register `host_addr` without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_sel | input | 2 | Selects device address 0x68 + addr_sel |
| bus_start | input | 1 | One-cycle pulse: START or repeated START seen |
| bus_stop | input | 1 | One-cycle pulse: STOP seen |
| scl_fall | input | 1 | One-cycle pulse: SCL fell |
| bit_valid | input | 1 | One-cycle pulse: SCL rose, `bit_in` holds the sampled SDA level |
| bit_in | input | 1 | SDA level sampled at the SCL rise |
| sda_low | output | 1 | 1 pulls SDA low (open-drain drive) |
| host_addr | input | 8 | Side-port register index |
| host_rdata | output | 8 | Committed content of register `host_addr` |

## Verification
The hardest state to reach from the ports is a full shadow buffer that keeps receiving bytes. That state must then be distinguished from a buffer that committed wrongly or stored past its limit. The stimulus sends a 40-byte block whose 32 accepted bytes wrap from the top of the register file to the bottom. It checks the acknowledge of every byte, checks that the file is unchanged just before STOP, and compares all 256 registers after STOP. A second hard case is a repeated START after buffered bytes. The bench follows it directly with a read-direction address so that the discarded block and the untouched pointer both show in the byte that comes back.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    L_IDLE,
    L_DEV,
    L_AHI,
    L_ALO,
    L_DATA,
    L_SEND,
    L_HALT
  } link_st_e;
endpackage

// File: rtl/srs_rst_sync.sv
module srs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/srs_link.sv
module srs_link import srs_pkg::*; #(
  parameter int         AW       = 8,
  parameter logic [6:0] DEV_BASE = 7'h68
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr_sel,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          scl_fall,
  input  logic          bit_valid,
  input  logic          bit_in,
  input  logic [7:0]    rd_data,
  input  logic          buf_room,
  output logic [AW-1:0] ptr,
  output logic          store,
  output logic [7:0]    store_byte,
  output logic          sda_low
);
  link_st_e      st_q, st_d;
  logic [3:0]    bp_q, bp_d;
  logic [6:0]    sh_q, sh_d;
  logic          ackp_q, ackp_d;
  logic          rw_q, rw_d;
  logic [7:0]    hi_q, hi_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [7:0]    txb_q, txb_d;
  logic          sda_q, sda_d;

  logic [7:0] byte_now;
  logic [6:0] dev_addr;
  logic       rx_phase;
  logic       active;

  assign byte_now   = {sh_q, bit_in};
  assign dev_addr   = DEV_BASE + {5'd0, addr_sel};
  assign rx_phase   = (st_q == L_DEV) || (st_q == L_AHI) ||
                      (st_q == L_ALO) || (st_q == L_DATA);
  assign active     = (st_q != L_IDLE) && (st_q != L_HALT);
  assign store_byte = byte_now;
  assign ptr        = ptr_q;
  assign sda_low    = sda_q;

  always_comb begin
    st_d   = st_q;
    bp_d   = bp_q;
    sh_d   = sh_q;
    ackp_d = ackp_q;
    rw_d   = rw_q;
    hi_d   = hi_q;
    ptr_d  = ptr_q;
    txb_d  = txb_q;
    sda_d  = sda_q;
    store  = 1'b0;
    if (bus_start) begin
      st_d   = L_DEV;
      bp_d   = 4'd0;
      ackp_d = 1'b0;
      sda_d  = 1'b0;
    end else if (bus_stop) begin
      st_d  = L_IDLE;
      bp_d  = 4'd0;
      sda_d = 1'b0;
    end else if (scl_fall) begin
      sda_d = 1'b0;
      if (rx_phase && bp_q == 4'd8) begin
        sda_d = ackp_q;
      end else if (st_q == L_SEND && bp_q < 4'd8) begin
        sda_d = ~txb_q[~bp_q[2:0]];
      end
    end else if (bit_valid && active) begin
      if (bp_q < 4'd8) begin
        bp_d = bp_q + 4'd1;
        if (st_q != L_SEND) begin
          sh_d = byte_now[6:0];
          if (bp_q == 4'd7) begin
            ackp_d = 1'b1;
            case (st_q)
              L_DEV: begin
                ackp_d = (byte_now[7:1] == dev_addr);
                rw_d   = byte_now[0];
              end
              L_AHI:  hi_d  = byte_now;
              L_ALO:  ptr_d = AW'({hi_q, byte_now});
              L_DATA: begin
                ackp_d = buf_room;
                store  = buf_room;
              end
              default: ackp_d = 1'b0;
            endcase
          end
        end
      end else begin
        bp_d = 4'd0;
        case (st_q)
          L_DEV: begin
            if (!ackp_q) begin
              st_d = L_HALT;
            end else if (rw_q) begin
              st_d  = L_SEND;
              txb_d = rd_data;
              ptr_d = ptr_q + AW'(1);
            end else begin
              st_d = L_AHI;
            end
          end
          L_AHI:  st_d = L_ALO;
          L_ALO:  st_d = L_DATA;
          L_DATA: st_d = L_DATA;
          L_SEND: begin
            if (bit_in) begin
              st_d = L_HALT;
            end else begin
              txb_d = rd_data;
              ptr_d = ptr_q + AW'(1);
            end
          end
          default: st_d = L_HALT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= L_IDLE;
      bp_q   <= 4'd0;
      sh_q   <= '0;
      ackp_q <= 1'b0;
      rw_q   <= 1'b0;
      hi_q   <= '0;
      ptr_q  <= '0;
      txb_q  <= '0;
      sda_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      bp_q   <= bp_d;
      sh_q   <= sh_d;
      ackp_q <= ackp_d;
      rw_q   <= rw_d;
      hi_q   <= hi_d;
      ptr_q  <= ptr_d;
      txb_q  <= txb_d;
      sda_q  <= sda_d;
    end
  end

  // R10: the drive level moves only on a falling SCL or a START/STOP
  assert_sda_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !bus_start && !bus_stop) |=> $stable(sda_q));

  // R8 / R1: an idle or halted link never pulls SDA
  assert_quiet_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == L_HALT) || (st_q == L_IDLE)) |-> !sda_q);

  // R7: data is only shifted out after a read-direction address
  assert_send_read_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == L_SEND) |-> rw_q);
endmodule

// File: rtl/srs_shadow.sv
module srs_shadow #(
  parameter int DEPTH = 32,
  localparam int SW   = $clog2(DEPTH),
  localparam int CW   = SW + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  stop,
  input  logic                  store,
  input  logic [7:0]            wbyte,
  output logic                  room,
  output logic                  commit,
  output logic [CW-1:0]         count,
  output logic [DEPTH-1:0][7:0] data
);
  logic [CW-1:0]         cnt_q, cnt_d;
  logic [DEPTH-1:0][7:0] buf_q;
  logic                  take;

  assign room   = (cnt_q < CW'(DEPTH));
  assign take   = store && room;
  assign commit = stop && (cnt_q != '0);
  assign count  = cnt_q;
  assign data   = buf_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || stop) cnt_d = '0;
    else if (take)     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic slot_en;
    assign slot_en = take && (cnt_q[SW-1:0] == SW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       buf_q[e] <= '0;
      else if (slot_en) buf_q[e] <= wbyte;
    end
  end

  // R6: the link only stores while the buffer has room
  assert_store_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> (cnt_q < CW'(DEPTH)));

  // R6: the fill level never exceeds the buffer size
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5: a START empties the buffer
  assert_start_discards_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile #(
  parameter int AW    = 8,
  parameter int DEPTH = 32,
  localparam int NREG = 1 << AW,
  localparam int SW   = $clog2(DEPTH),
  localparam int CW   = SW + 1,
  localparam int MW   = (AW > CW) ? AW : CW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [AW-1:0]         base,
  input  logic [CW-1:0]         count,
  input  logic [DEPTH-1:0][7:0] sdata,
  input  logic [AW-1:0]         bus_addr,
  input  logic [AW-1:0]         host_addr,
  output logic [7:0]            bus_rdata,
  output logic [7:0]            host_rdata
);
  logic [7:0] mem_q [NREG];

  for (genvar j = 0; j < NREG; j++) begin : g_reg
    logic [AW-1:0] off;
    logic          hit;
    assign off = AW'(j) - base;
    assign hit = commit && (MW'(off) < MW'(count));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[j] <= '0;
      else if (hit) mem_q[j] <= sdata[off[SW-1:0]];
    end
  end

  assign bus_rdata  = mem_q[bus_addr];
  assign host_rdata = mem_q[host_addr];

  // R4: without a commit the observed register content holds
  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> (!$stable(host_addr) || $stable(host_rdata)));
endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave #(
  parameter int         AW       = 8,
  parameter int         DEPTH    = 32,
  parameter logic [6:0] DEV_BASE = 7'h68,
  localparam int        CW       = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr_sel,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          scl_fall,
  input  logic          bit_valid,
  input  logic          bit_in,
  output logic          sda_low,
  input  logic [AW-1:0] host_addr,
  output logic [7:0]    host_rdata
);
  logic                  srst_n;
  logic [AW-1:0]         ptr;
  logic                  store;
  logic [7:0]            store_byte;
  logic                  room;
  logic                  commit;
  logic [CW-1:0]         count;
  logic [DEPTH-1:0][7:0] sdata;
  logic [7:0]            bus_rdata;

  srs_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  srs_link #(.AW(AW), .DEV_BASE(DEV_BASE)) u_link (
    .clk        (clk),
    .rst_n      (srst_n),
    .addr_sel   (addr_sel),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .scl_fall   (scl_fall),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .rd_data    (bus_rdata),
    .buf_room   (room),
    .ptr        (ptr),
    .store      (store),
    .store_byte (store_byte),
    .sda_low    (sda_low)
  );

  srs_shadow #(.DEPTH(DEPTH)) u_shadow (
    .clk    (clk),
    .rst_n  (srst_n),
    .clear  (bus_start),
    .stop   (bus_stop),
    .store  (store),
    .wbyte  (store_byte),
    .room   (room),
    .commit (commit),
    .count  (count),
    .data   (sdata)
  );

  srs_regfile #(.AW(AW), .DEPTH(DEPTH)) u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .commit     (commit),
    .base       (ptr),
    .count      (count),
    .sdata      (sdata),
    .bus_addr   (ptr),
    .host_addr  (host_addr),
    .bus_rdata  (bus_rdata),
    .host_rdata (host_rdata)
  );
endmodule

// File: tb/tb_serial_reg_slave.sv
module tb_serial_reg_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr_sel = 2'd0;
  logic       bus_start = 1'b0;
  logic       bus_stop = 1'b0;
  logic       scl_fall = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b1;
  logic       sda_low;
  logic [7:0] host_addr = 8'd0;
  logic [7:0] host_rdata;

  always #4 clk = ~clk;

  serial_reg_slave dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_sel   (addr_sel),
    .bus_start  (bus_start),
    .bus_stop   (bus_stop),
    .scl_fall   (scl_fall),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .sda_low    (sda_low),
    .host_addr  (host_addr),
    .host_rdata (host_rdata)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;
  logic [7:0] ref_q [256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic mb, output logic sb);
    logic s2;
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    repeat (2) @(negedge clk);
    sb = sda_low;
    bit_in = mb & ~sda_low;
    bit_valid = 1'b1;
    @(negedge clk) bit_valid = 1'b0;
    s2 = sda_low;
    chk(s2 == sb, "R10 drive held between falls", s2, sb);
  endtask

  task automatic bstart();
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
  endtask

  task automatic bstop();
    @(negedge clk) scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
    @(negedge clk);
    chk(sda_low == 1'b0, "R10 released at STOP", sda_low, 0);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) xfer_bit(b[i], s);
    xfer_bit(1'b1, s);
    ack = s;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(1'b1, s);
      d[i] = ~s;
    end
    xfer_bit(nack, s);
  endtask

  task automatic check_all(input string tag);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk) host_addr = 8'(a);
      #2;
      chk(host_rdata == ref_q[a], tag, host_rdata, ref_q[a]);
    end
  endtask

  function automatic logic [7:0] dev_byte(input int sel, input logic rw);
    return {7'(7'h68 + sel), rw};
  endfunction

  task automatic header(input int sel, input int base, input int seed);
    logic a;
    addr_sel = 2'(sel);
    bstart();
    wr_byte(dev_byte(sel, 1'b0), a);
    chk(a == 1'b1, "R1 own address acked", a, 1);
    wr_byte(8'(seed * 3 + 1), a);
    chk(a == 1'b1, "R2 high address byte acked", a, 1);
    wr_byte(8'(base), a);
    chk(a == 1'b1, "R2 low address byte acked", a, 1);
  endtask

  task automatic do_write(input int sel, input int base, input int n, input int seed,
                          input bit finish);
    logic       a;
    logic [7:0] d;
    logic [7:0] pend [256];
    bit         pv [256];
    for (int k = 0; k < 256; k++) pv[k] = 1'b0;
    header(sel, base, seed);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed * 37 + i * 13 + 5);
      wr_byte(d, a);
      chk(a == (i < 32), "R6 data ack only within buffer size", a, (i < 32));
      if (i < 32) begin
        pend[(base + i) % 256] = d;
        pv[(base + i) % 256] = 1'b1;
      end
    end
    check_all("R4 registers unchanged before STOP");
    if (finish) begin
      bstop();
      for (int k = 0; k < 256; k++) if (pv[k]) ref_q[k] = pend[k];
      check_all("R3 R6 block committed at STOP");
    end else begin
      bstart();
      wr_byte(dev_byte(sel, 1'b1), a);
      chk(a == 1'b1, "R1 read address acked", a, 1);
      rd_byte(1'b1, d);
      chk(d == ref_q[base % 256], "R7 pointer untouched by write data", d, ref_q[base % 256]);
      bstop();
      check_all("R5 repeated START discards block");
    end
  endtask

  task automatic do_read(input int sel, input int base, input int n);
    logic       a;
    logic       s;
    logic [7:0] d;
    header(sel, base, base);
    bstart();
    wr_byte(dev_byte(sel, 1'b1), a);
    chk(a == 1'b1, "R1 read address acked", a, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i == n - 1, d);
      chk(d == ref_q[(base + i) % 256], "R7 sequential read data", d, ref_q[(base + i) % 256]);
    end
    for (int k = 0; k < 9; k++) begin
      xfer_bit(1'b0, s);
      chk(s == 1'b0, "R8 silent after master NACK", s, 0);
    end
    bstop();
  endtask

  initial begin
    logic a;
    for (int k = 0; k < 256; k++) ref_q[k] = 8'd0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_low == 1'b0, "R9 SDA released after reset", sda_low, 0);
    check_all("R9 R11 registers zero after reset");

    // R1: every device address against every select setting
    for (int sel = 0; sel < 4; sel++) begin
      addr_sel = 2'(sel);
      for (int da = 0; da < 128; da++) begin
        bstart();
        wr_byte({7'(da), 1'b0}, a);
        chk(a == (da == 8'h68 + sel), "R1 address match", a, (da == 8'h68 + sel));
        if (da != 8'h68 + sel) begin
          wr_byte(8'hA5, a);
          chk(a == 1'b0, "R1 no response after foreign address", a, 0);
        end
        bstop();
      end
    end

    do_write(0, 8'h10, 1, 1, 1'b1);
    do_write(1, 8'h40, 7, 2, 1'b1);
    do_write(2, 8'hF0, 32, 3, 1'b1);
    do_write(3, 8'hE8, 40, 4, 1'b1);
    do_write(0, 8'h41, 5, 5, 1'b0);
    do_write(3, 8'hFE, 3, 6, 1'b0);
    do_read(0, 8'hF8, 12);
    do_read(2, 8'h40, 7);
    do_read(1, 8'h10, 1);
    check_all("R11 host port after reads");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule